// File: doc/BRIEF.md
# Busy-Time Read Status Generator

This block sits on the read path of a word-wide nonvolatile array. While an internal word program or block erase runs, the array cannot return data. This block builds the status word that a read returns in its place. A host finds out that the operation has finished in one of two ways. It can compare bit 7 against the value it wrote. It can also watch bit 6, which flips on each read access. When the busy flag drops, reads again pass the array data through unchanged.

The operation engine supplies the busy flag and the operation kind. The write path supplies the word being programmed. The bus interface gives one rising edge of `rd_strobe` per output-enable or chip-enable read access. Reads are plain strobed accesses, so no valid/ready handshake is used and no back-pressure exists. The block returns its value combinationally on every cycle. The `wr_discard` output tells the command decoder to drop incoming writes while an operation is in flight. An abort input ends the busy view at once and returns the block to passthrough.

Top module: `op_status_reporter`

## Requirements
- R1: When `op_busy` is 0, `rd_data` equals `array_data` on every bit in the same cycle.
- R2: While busy with `op_kind` = 0 (word program), bit 7 of `rd_data` is the inverse of bit 7 of `prog_word`.
- R3: While busy with `op_kind` = 1 (erase), bit 7 of `rd_data` is 0.
- R4: While busy, each rising edge of `rd_strobe` (strobe high in a cycle after a low cycle) inverts bit 6 of `rd_data`. The new value is visible from the cycle after the clock edge that samples the rise.
- R5: Bit 6 holds its value when the strobe stays high or stays low. It also holds across strobe rises taken while not busy or while `hw_reset` is high, so the next busy period continues from the held value.
- R6: While busy, bits 15..8 and 5..0 of `rd_data` are 0.
- R7: `wr_discard` is 1 exactly when `op_busy` is 1 and `hw_reset` is 0, in the same cycle.
- R8: `hw_reset` = 1 forces passthrough of `array_data` and `wr_discard` = 0 in the same cycle, even with `op_busy` = 1.
- R9: After `rst_n` is released, bit 6 starts at 0, so the first busy read before any strobe shows bit 6 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the toggle and strobe history |
| hw_reset | input | 1 | Abort: ends the busy view at once |
| op_busy | input | 1 | Internal program or erase in progress |
| op_kind | input | 1 | 0 = word program, 1 = erase |
| prog_word | input | 16 | Word being programmed |
| array_data | input | 16 | Array read data |
| rd_strobe | input | 1 | High during a read access; each rise is one access |
| rd_data | output | 16 | Value returned to the bus |
| wr_discard | output | 1 | Writes arriving now must be dropped |

## Verification
A strobe rise can land in the same cycle as the abort input, or in the cycle where busy ends. The toggle must then stay where it was. The bench raises `rd_strobe` while `hw_reset` is high, and again after `op_busy` has dropped. It then re-enters busy and checks that bit 6 carries the value predicted by its own count of the rises that were taken while busy. It also holds the strobe high across several cycles to show that a level is not taken as a new access.

// File: rtl/osr_pkg.sv
package osr_pkg;
  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } op_kind_e;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned POLL_POS = 7;
  localparam int unsigned TGL_POS  = 6;
endpackage

// File: rtl/osr_strobe_edge.sv
module osr_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe;
  end

  assign rise = strobe & ~strobe_q;
endmodule

// File: rtl/osr_toggle.sv
module osr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic advance,
  output logic tgl
);
  logic tgl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       tgl_q <= 1'b0;
    else if (advance) tgl_q <= ~tgl_q;
  end

  assign tgl = tgl_q;
endmodule

// File: rtl/osr_status_mux.sv
module osr_status_mux #(
  parameter int unsigned W        = osr_pkg::WORD_W,
  parameter int unsigned POLL_BIT = osr_pkg::POLL_POS,
  parameter int unsigned TGL_BIT  = osr_pkg::TGL_POS
) (
  input  logic         busy,
  input  logic         kind,
  input  logic [W-1:0] prog_word,
  input  logic [W-1:0] array_data,
  input  logic         tgl,
  output logic [W-1:0] out_data
);
  import osr_pkg::*;

  logic [W-1:0] status;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign status[i] = (kind == OP_PROGRAM) ? ~prog_word[i] : 1'b0;
    end else if (i == TGL_BIT) begin : g_tgl
      assign status[i] = tgl;
    end else begin : g_zero
      assign status[i] = 1'b0;
    end
  end

  assign out_data = busy ? status : array_data;
endmodule

// File: rtl/op_status_reporter.sv
module op_status_reporter #(
  parameter int unsigned W        = osr_pkg::WORD_W,
  parameter int unsigned POLL_BIT = osr_pkg::POLL_POS,
  parameter int unsigned TGL_BIT  = osr_pkg::TGL_POS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_reset,
  input  logic         op_busy,
  input  logic         op_kind,
  input  logic [W-1:0] prog_word,
  input  logic [W-1:0] array_data,
  input  logic         rd_strobe,
  output logic [W-1:0] rd_data,
  output logic         wr_discard
);
  logic busy_eff;
  logic strobe_rise;
  logic tgl;

  // abort overrides the engine's busy flag in the same cycle
  assign busy_eff = op_busy & ~hw_reset;

  osr_strobe_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (rd_strobe),
    .rise   (strobe_rise)
  );

  osr_toggle u_tgl (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (strobe_rise & busy_eff),
    .tgl     (tgl)
  );

  osr_status_mux #(
    .W        (W),
    .POLL_BIT (POLL_BIT),
    .TGL_BIT  (TGL_BIT)
  ) u_mux (
    .busy       (busy_eff),
    .kind       (op_kind),
    .prog_word  (prog_word),
    .array_data (array_data),
    .tgl        (tgl),
    .out_data   (rd_data)
  );

  assign wr_discard = busy_eff;
endmodule

// File: rtl/op_status_reporter_chk.sv
module op_status_reporter_chk #(
  parameter int unsigned W        = 16,
  parameter int unsigned POLL_BIT = 7,
  parameter int unsigned TGL_BIT  = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hw_reset,
  input logic         op_busy,
  input logic         op_kind,
  input logic [W-1:0] prog_word,
  input logic [W-1:0] array_data,
  input logic         rd_strobe,
  input logic [W-1:0] rd_data,
  input logic         wr_discard
);
  logic stb_q, past_ok, bsy;
  logic [W-1:0] zmask;

  assign bsy = op_busy && !hw_reset;
  always_comb begin
    zmask = '1;
    zmask[POLL_BIT] = 1'b0;
    zmask[TGL_BIT]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      past_ok <= 1'b0;
    end else begin
      stb_q   <= rd_strobe;
      past_ok <= 1'b1;
    end
  end

  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !op_busy |-> rd_data == array_data);

  a_r2_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && op_kind == 1'b0) |-> rd_data[POLL_BIT] == !prog_word[POLL_BIT]);

  a_r3_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && op_kind == 1'b1) |-> rd_data[POLL_BIT] == 1'b0);

  a_r4_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && rd_strobe && !stb_q) |=> (!bsy || rd_data[TGL_BIT] != $past(rd_data[TGL_BIT])));

  a_r5_toggle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && bsy && $past(bsy) && !($past(rd_strobe) && !$past(stb_q)))
      |-> $stable(rd_data[TGL_BIT]));

  a_r6_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    bsy |-> (rd_data & zmask) == '0);

  a_r7_discard: assert property (@(posedge clk) disable iff (!rst_n)
    wr_discard == bsy);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reset |-> (rd_data == array_data && !wr_discard));
endmodule

bind op_status_reporter op_status_reporter_chk #(
  .W (W), .POLL_BIT (POLL_BIT), .TGL_BIT (TGL_BIT)
) u_chk (.*);

// File: tb/op_status_reporter_tb.sv
module op_status_reporter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_reset = 1'b0;
  logic        op_busy = 1'b0;
  logic        op_kind = 1'b0;
  logic [15:0] prog_word = '0;
  logic [15:0] array_data = '0;
  logic        rd_strobe = 1'b0;
  logic [15:0] rd_data;
  logic        wr_discard;

  int errors = 0;
  int checks = 0;
  logic exp_tgl = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  op_status_reporter u_dut (
    .clk (clk), .rst_n (rst_n), .hw_reset (hw_reset), .op_busy (op_busy),
    .op_kind (op_kind), .prog_word (prog_word), .array_data (array_data),
    .rd_strobe (rd_strobe), .rd_data (rd_data), .wr_discard (wr_discard)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [15:0] busy_word(input logic k, input logic [15:0] pw, input logic t);
    logic [15:0] w;
    w = 16'h0000;
    w[7] = (k == 1'b0) ? ~pw[7] : 1'b0;
    w[6] = t;
    return w;
  endfunction

  task automatic chk_busy(input string req);
    #2;
    chk(req, rd_data, busy_word(op_kind, prog_word, exp_tgl));
    chk("R7", {15'd0, wr_discard}, 16'd1);
  endtask

  task automatic chk_idle(input string req);
    #2;
    chk(req, rd_data, array_data);
    chk("R7", {15'd0, wr_discard}, 16'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] pws [4];
    logic [15:0] ads [2];
    bit first;
    pws[0] = 16'h0000; pws[1] = 16'h0080; pws[2] = 16'hFF7F; pws[3] = 16'hFFFF;
    ads[0] = 16'h1234; ads[1] = 16'hEDCB;
    first = 1'b1;

    array_data = 16'hA5C3;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk_idle("R1 reset passthrough");

    for (int k = 0; k < 2; k++) begin
      for (int p = 0; p < 4; p++) begin
        for (int a = 0; a < 2; a++) begin
          op_kind = k[0];
          prog_word = pws[p];
          array_data = ads[a];
          op_busy = 1'b1;
          // R9 first busy read shows toggle reset value
          chk_busy(first ? "R9 initial toggle" : (k == 0 ? "R2 program poll" : "R3 erase poll"));
          first = 1'b0;
          for (int n = 0; n < 3; n++) begin
            tick();
            rd_strobe = 1'b1;
            chk_busy("R6 before rise");
            tick();
            exp_tgl = ~exp_tgl;
            chk_busy("R4 toggle after rise");
            tick();
            chk_busy("R5 strobe held high");
            rd_strobe = 1'b0;
            tick();
            chk_busy("R5 strobe low");
          end
          // abort with a strobe rise in the same cycle
          hw_reset = 1'b1;
          rd_strobe = 1'b1;
          chk_idle("R8 abort passthrough");
          tick();
          chk_idle("R8 abort held");
          rd_strobe = 1'b0;
          tick();
          hw_reset = 1'b0;
          chk_busy("R5 no toggle during abort");
          // completion, then a rise while idle
          tick();
          op_busy = 1'b0;
          chk_idle("R1 after completion");
          rd_strobe = 1'b1;
          tick();
          chk_idle("R1 idle read");
          rd_strobe = 1'b0;
          tick();
          op_busy = 1'b1;
          chk_busy("R5 no toggle while idle");
          tick();
          op_busy = 1'b0;
          tick();
        end
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule